// File: doc/BRIEF.md
# TDM Time-Slot Route Sequencer

This block steps through a run-length route table once per TDM frame. It decides, slot by slot, which of five internal serial channels owns the current slot, or marks the slot as idle. The receive direction and the transmit direction each have their own table and their own sequencer. Each table entry is a run: a slot count and a destination. Runs are consumed in table order starting at slot 0. A run covers that many consecutive slots, then the sequencer steps to the next entry.

Software-side logic loads entries through one write port, which carries a direction select, an entry index, a count, a destination, a reserved flags field and an end-of-table marker. Writes go into a shadow copy. The shadow is swapped into the working copy on the frame-start pulse, so a frame is always routed by a single consistent table. The framing logic supplies a frame-start pulse and a slot-boundary strobe. For each direction the block returns the destination code, an active flag and the running slot number.

Top module: `tdm_route_seq`

## Requirements
- R1: While reset is asserted and after reset is released, both directions report destination 0, active 0 and slot 0, and `wr_err` is 0.
- R2: Destination codes are 0 for an idle slot and 1 to 5 for the five channels. Starting from slot 0, entry k covers the `count` slots that follow the slots of entries 0..k-1. The active flag is 1 exactly when the reported destination is non-zero.
- R3: A run count may be any value from 1 to 64, and a table may hold up to 64 entries. A table of 64 entries whose final run is 64 slots long is walked in full.
- R4: The receive table and the transmit table are independent. A write with `wr_tx`=0 changes only the receive routing, and a write with `wr_tx`=1 changes only the transmit routing.
- R5: A frame-start pulse sends both sequencers back to slot 0 and entry 0 from any state, including the middle of a run. If a slot strobe arrives in the same cycle, the frame-start pulse wins.
- R6: Once the last entry (the one written with `wr_last`=1, so table length = index+1) has been used up, every remaining slot of the frame reports destination 0. A table that has never been terminated reports destination 0 for every slot.
- R7: A write is rejected when its count is 0, its count is above 64, its destination is above 5, or its flags are non-zero. A rejected write leaves both tables unchanged and sets `wr_err`, which stays at 1 until reset.
- R8: Accepted writes reach routing only at the next frame-start pulse. The frame already in progress keeps the routing it started with.
- R9: Each slot strobe without a frame-start pulse adds one to the slot number (modulo 2^SLOT_W). In a cycle with neither strobe nor frame start, the destination and slot outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_start | input | 1 | One-cycle pulse marking slot 0 of a new frame |
| slot_strobe | input | 1 | One-cycle pulse moving to the next slot |
| wr_en | input | 1 | Table write enable |
| wr_tx | input | 1 | Table select: 0 receive, 1 transmit |
| wr_idx | input | 6 | Entry index |
| wr_count | input | 7 | Run length in slots (1..64) |
| wr_dest | input | 3 | Destination code (0 idle, 1..5 channel) |
| wr_flags | input | 4 | Reserved, must be zero |
| wr_last | input | 1 | This entry ends the table |
| rx_dest | output | 3 | Receive destination of the current slot |
| rx_active | output | 1 | Receive slot is routed to a channel |
| rx_slot | output | 8 | Receive slot number |
| tx_dest | output | 3 | Transmit destination of the current slot |
| tx_active | output | 1 | Transmit slot is routed to a channel |
| tx_slot | output | 8 | Transmit slot number |
| wr_err | output | 1 | Sticky flag for rejected writes |

## Verification
The slot, destination and active outputs take their new values at the same clock edge that samples a frame-start pulse or a slot strobe. `wr_err` rises at the edge that samples a bad write. A written entry becomes visible only after the edge that samples the next frame-start pulse. Every stimulus in the bench lasts exactly one edge, and all outputs are read 1 ns after that edge. The expected values come from the bench's own copy of the shadow and working tables, and that copy is swapped at the same edge as the design's.

// File: rtl/tdm_route_pkg.sv
package tdm_route_pkg;
  localparam int DEST_W   = 3;
  localparam int NUM_CHAN = 5;
  localparam int NUM_DIR  = 2;

  typedef enum logic [DEST_W-1:0] {
    DST_IDLE = 3'd0,
    DST_CH1  = 3'd1,
    DST_CH2  = 3'd2,
    DST_CH3  = 3'd3,
    DST_CH4  = 3'd4,
    DST_CH5  = 3'd5
  } dest_e;

  function automatic logic dest_legal(input logic [DEST_W-1:0] d);
    return d <= DEST_W'(NUM_CHAN);
  endfunction
endpackage

// File: rtl/tdm_route_table.sv
module tdm_route_table #(
  parameter int MAX_ENTRIES = 64,
  parameter int COUNT_W     = 7,
  parameter int IDX_W       = 6,
  parameter int LEN_W       = 7,
  parameter int DEST_W      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [COUNT_W-1:0] wr_count,
  input  logic [DEST_W-1:0]  wr_dest,
  input  logic               wr_last,
  input  logic               swap,
  input  logic [IDX_W-1:0]   cur_idx,
  input  logic [IDX_W-1:0]   nxt_idx,
  output logic [DEST_W-1:0]  cur_dest,
  output logic [COUNT_W-1:0] nxt_count,
  output logic [COUNT_W-1:0] head_count,
  output logic [LEN_W-1:0]   shd_len,
  output logic [LEN_W-1:0]   act_len
);
  // shadow copy takes writes; working copy is loaded on swap
  logic [COUNT_W-1:0] shd_cnt_q [MAX_ENTRIES];
  logic [DEST_W-1:0]  shd_dst_q [MAX_ENTRIES];
  logic [COUNT_W-1:0] act_cnt_q [MAX_ENTRIES];
  logic [DEST_W-1:0]  act_dst_q [MAX_ENTRIES];
  logic [LEN_W-1:0]   shd_len_q, act_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_ENTRIES; i++) begin
        shd_cnt_q[i] <= '0;
        shd_dst_q[i] <= '0;
        act_cnt_q[i] <= '0;
        act_dst_q[i] <= '0;
      end
      shd_len_q <= '0;
      act_len_q <= '0;
    end else begin
      if (wr_en) begin
        shd_cnt_q[wr_idx] <= wr_count;
        shd_dst_q[wr_idx] <= wr_dest;
        if (wr_last) shd_len_q <= LEN_W'(wr_idx) + LEN_W'(1);
      end
      if (swap) begin
        act_cnt_q <= shd_cnt_q;
        act_dst_q <= shd_dst_q;
        act_len_q <= shd_len_q;
      end
    end
  end

  assign cur_dest   = act_dst_q[cur_idx];
  assign nxt_count  = act_cnt_q[nxt_idx];
  assign head_count = shd_cnt_q[0];
  assign shd_len    = shd_len_q;
  assign act_len    = act_len_q;
endmodule

// File: rtl/tdm_route_walker.sv
module tdm_route_walker #(
  parameter int SLOT_W  = 8,
  parameter int COUNT_W = 7,
  parameter int IDX_W   = 6,
  parameter int LEN_W   = 7,
  parameter int DEST_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               slot_strobe,
  input  logic [COUNT_W-1:0] head_count,
  input  logic [LEN_W-1:0]   shd_len,
  input  logic [LEN_W-1:0]   act_len,
  input  logic [DEST_W-1:0]  cur_dest,
  input  logic [COUNT_W-1:0] nxt_count,
  output logic [IDX_W-1:0]   cur_idx,
  output logic [IDX_W-1:0]   nxt_idx,
  output logic [DEST_W-1:0]  dest,
  output logic               active,
  output logic [SLOT_W-1:0]  slot
);
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic [IDX_W-1:0]   entry_q, entry_d;
  logic [COUNT_W-1:0] left_q, left_d;
  logic               done_q, done_d;
  logic               last_entry;

  assign last_entry = (LEN_W'(entry_q) + LEN_W'(1)) >= act_len;

  always_comb begin
    slot_d  = slot_q;
    entry_d = entry_q;
    left_d  = left_q;
    done_d  = done_q;
    if (frame_start) begin
      slot_d  = '0;
      entry_d = '0;
      left_d  = head_count;
      done_d  = (shd_len == '0);
    end else if (slot_strobe) begin
      slot_d = slot_q + SLOT_W'(1);
      if (!done_q) begin
        if (left_q <= COUNT_W'(1)) begin
          if (last_entry) begin
            done_d = 1'b1;
          end else begin
            entry_d = entry_q + IDX_W'(1);
            left_d  = nxt_count;
          end
        end else begin
          left_d = left_q - COUNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      entry_q <= '0;
      left_q  <= '0;
      done_q  <= 1'b1;
    end else if (frame_start || slot_strobe) begin
      slot_q  <= slot_d;
      entry_q <= entry_d;
      left_q  <= left_d;
      done_q  <= done_d;
    end
  end

  assign cur_idx = entry_q;
  assign nxt_idx = entry_q + IDX_W'(1);
  assign dest    = done_q ? '0 : cur_dest;
  assign active  = (dest != '0);
  assign slot    = slot_q;
endmodule

// File: rtl/tdm_route_seq.sv
module tdm_route_seq
  import tdm_route_pkg::*;
#(
  parameter int SLOT_W      = 8,
  parameter int MAX_ENTRIES = 64,
  parameter int MAX_RUN     = 64,
  parameter int FLAG_W      = 4,
  localparam int IDX_W      = $clog2(MAX_ENTRIES),
  localparam int LEN_W      = $clog2(MAX_ENTRIES + 1),
  localparam int COUNT_W    = $clog2(MAX_RUN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               slot_strobe,
  input  logic               wr_en,
  input  logic               wr_tx,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [COUNT_W-1:0] wr_count,
  input  logic [DEST_W-1:0]  wr_dest,
  input  logic [FLAG_W-1:0]  wr_flags,
  input  logic               wr_last,
  output logic [DEST_W-1:0]  rx_dest,
  output logic               rx_active,
  output logic [SLOT_W-1:0]  rx_slot,
  output logic [DEST_W-1:0]  tx_dest,
  output logic               tx_active,
  output logic [SLOT_W-1:0]  tx_slot,
  output logic               wr_err
);
  logic wr_bad, err_q, err_d;
  logic [DEST_W-1:0] dest_w   [NUM_DIR];
  logic              active_w [NUM_DIR];
  logic [SLOT_W-1:0] slot_w   [NUM_DIR];

  // write screening: zero or oversized run, unknown channel, reserved bits set
  assign wr_bad = (wr_count == '0) || (wr_count > COUNT_W'(MAX_RUN)) ||
                  !dest_legal(wr_dest) || (wr_flags != '0);

  assign err_d = err_q | (wr_en & wr_bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    logic [IDX_W-1:0]   cur_idx, nxt_idx;
    logic [DEST_W-1:0]  cur_dest;
    logic [COUNT_W-1:0] nxt_count, head_count;
    logic [LEN_W-1:0]   shd_len, act_len;
    logic               tbl_wr;

    assign tbl_wr = wr_en && !wr_bad && (wr_tx == d[0]);

    tdm_route_table #(
      .MAX_ENTRIES(MAX_ENTRIES), .COUNT_W(COUNT_W), .IDX_W(IDX_W),
      .LEN_W(LEN_W), .DEST_W(DEST_W)
    ) u_table (
      .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr), .wr_idx(wr_idx),
      .wr_count(wr_count), .wr_dest(wr_dest), .wr_last(wr_last),
      .swap(frame_start), .cur_idx(cur_idx), .nxt_idx(nxt_idx),
      .cur_dest(cur_dest), .nxt_count(nxt_count), .head_count(head_count),
      .shd_len(shd_len), .act_len(act_len)
    );

    tdm_route_walker #(
      .SLOT_W(SLOT_W), .COUNT_W(COUNT_W), .IDX_W(IDX_W),
      .LEN_W(LEN_W), .DEST_W(DEST_W)
    ) u_walker (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .slot_strobe(slot_strobe), .head_count(head_count), .shd_len(shd_len),
      .act_len(act_len), .cur_dest(cur_dest), .nxt_count(nxt_count),
      .cur_idx(cur_idx), .nxt_idx(nxt_idx), .dest(dest_w[d]),
      .active(active_w[d]), .slot(slot_w[d])
    );
  end

  assign rx_dest   = dest_w[0];
  assign rx_active = active_w[0];
  assign rx_slot   = slot_w[0];
  assign tx_dest   = dest_w[1];
  assign tx_active = active_w[1];
  assign tx_slot   = slot_w[1];
  assign wr_err    = err_q;
endmodule

// File: rtl/tdm_route_seq_chk.sv
module tdm_route_seq_chk #(
  parameter int SLOT_W  = 8,
  parameter int MAX_RUN = 64,
  parameter int COUNT_W = 7,
  parameter int FLAG_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               slot_strobe,
  input logic               wr_en,
  input logic [COUNT_W-1:0] wr_count,
  input logic [2:0]         wr_dest,
  input logic [FLAG_W-1:0]  wr_flags,
  input logic [2:0]         rx_dest,
  input logic [SLOT_W-1:0]  rx_slot,
  input logic [2:0]         tx_dest,
  input logic [SLOT_W-1:0]  tx_slot,
  input logic               wr_err
);
  logic bad_wr;
  assign bad_wr = wr_en && ((wr_count == '0) || (wr_count > COUNT_W'(MAX_RUN)) ||
                            (wr_dest > 3'd5) || (wr_flags != '0));

  AST_DEST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dest <= 3'd5) && (tx_dest <= 3'd5)); // R2

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (rx_slot == '0) && (tx_slot == '0)); // R5

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_strobe && !frame_start) |=> rx_slot == SLOT_W'($past(rx_slot) + 1'b1)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_strobe && !frame_start) |=>
      $stable(rx_dest) && $stable(tx_dest) && $stable(rx_slot) && $stable(tx_slot)); // R9

  AST_BAD_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> wr_err); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err); // R7
endmodule

bind tdm_route_seq tdm_route_seq_chk #(
  .SLOT_W(SLOT_W), .MAX_RUN(MAX_RUN), .COUNT_W(COUNT_W), .FLAG_W(FLAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .slot_strobe(slot_strobe),
  .wr_en(wr_en), .wr_count(wr_count), .wr_dest(wr_dest), .wr_flags(wr_flags),
  .rx_dest(rx_dest), .rx_slot(rx_slot), .tx_dest(tx_dest), .tx_slot(tx_slot),
  .wr_err(wr_err)
);

// File: tb/tb_tdm_route_seq.sv
module tb_tdm_route_seq;
  logic clk = 1'b0;
  logic rst_n, frame_start, slot_strobe, wr_en, wr_tx, wr_last;
  logic [5:0] wr_idx;
  logic [6:0] wr_count;
  logic [2:0] wr_dest;
  logic [3:0] wr_flags;
  logic [2:0] rx_dest, tx_dest;
  logic       rx_active, tx_active, wr_err;
  logic [7:0] rx_slot, tx_slot;

  always #4 clk = ~clk;

  tdm_route_seq dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .slot_strobe(slot_strobe),
    .wr_en(wr_en), .wr_tx(wr_tx), .wr_idx(wr_idx), .wr_count(wr_count),
    .wr_dest(wr_dest), .wr_flags(wr_flags), .wr_last(wr_last),
    .rx_dest(rx_dest), .rx_active(rx_active), .rx_slot(rx_slot),
    .tx_dest(tx_dest), .tx_active(tx_active), .tx_slot(tx_slot), .wr_err(wr_err)
  );

  int checks = 0, errors = 0;
  int s_cnt [2][64], s_dst [2][64], s_len [2];
  int a_cnt [2][64], a_dst [2][64], a_len [2];
  int cur_slot = 0;
  bit err_m = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (slot %0d)", req, what, act, exp, cur_slot);
    end
  endtask

  function automatic int exp_dest(int d, int s);
    int base = 0;
    for (int e = 0; e < a_len[d]; e++) begin
      if (s < base + a_cnt[d][e]) return a_dst[d][e];
      base += a_cnt[d][e];
    end
    return 0;
  endfunction

  task automatic check_slot(string req);
    int ed;
    ed = exp_dest(0, cur_slot);
    chk(int'(rx_dest) == ed, req, "rx_dest", int'(rx_dest), ed);
    chk(rx_active == (ed != 0), req, "rx_active", int'(rx_active), int'(ed != 0));
    chk(int'(rx_slot) == cur_slot % 256, req, "rx_slot", int'(rx_slot), cur_slot % 256);
    ed = exp_dest(1, cur_slot);
    chk(int'(tx_dest) == ed, req, "tx_dest", int'(tx_dest), ed);
    chk(tx_active == (ed != 0), req, "tx_active", int'(tx_active), int'(ed != 0));
    chk(int'(tx_slot) == cur_slot % 256, req, "tx_slot", int'(tx_slot), cur_slot % 256);
  endtask

  task automatic tick(bit fs, bit st);
    frame_start = fs;
    slot_strobe = st;
    @(posedge clk);
    #1;
    frame_start = 0;
    slot_strobe = 0;
    if (fs) begin
      a_cnt = s_cnt;
      a_dst = s_dst;
      a_len = s_len;
      cur_slot = 0;
    end else if (st) begin
      cur_slot++;
    end
  endtask

  task automatic new_frame(string req);
    tick(1, 0);
    check_slot(req);
  endtask

  task automatic next_slot(string req);
    tick(0, 1);
    check_slot(req);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) tick(0, 0);
    check_slot(req);
  endtask

  task automatic wr(int d, int idx, int cnt, int dst, int flg, bit last);
    bit bad;
    wr_en = 1; wr_tx = d[0]; wr_idx = 6'(idx); wr_count = 7'(cnt);
    wr_dest = 3'(dst); wr_flags = 4'(flg); wr_last = last;
    @(posedge clk);
    #1;
    wr_en = 0; wr_last = 0;
    bad = (cnt == 0) || (cnt > 64) || (dst > 5) || (flg != 0);
    if (bad) err_m = 1;
    else begin
      s_cnt[d][idx] = cnt;
      s_dst[d][idx] = dst;
      if (last) s_len[d] = idx + 1;
    end
    chk(wr_err == err_m, "R7", "wr_err", int'(wr_err), int'(err_m));
  endtask

  task automatic walk(int n, string req);
    for (int i = 0; i < n; i++) next_slot(req);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int len, tot;
    seed = 32'h1d2c3b4a;
    void'($urandom(seed));
    for (int d = 0; d < 2; d++) begin
      s_len[d] = 0; a_len[d] = 0;
      for (int e = 0; e < 64; e++) begin
        s_cnt[d][e] = 0; s_dst[d][e] = 0; a_cnt[d][e] = 0; a_dst[d][e] = 0;
      end
    end
    rst_n = 0; frame_start = 0; slot_strobe = 0; wr_en = 0; wr_tx = 0;
    wr_idx = 0; wr_count = 0; wr_dest = 0; wr_flags = 0; wr_last = 0;
    repeat (3) @(posedge clk);
    #1;
    check_slot("R1");
    chk(wr_err == 0, "R1", "wr_err", int'(wr_err), 0);
    @(negedge clk);
    rst_n = 1;
    #1;
    check_slot("R1");

    // R6: no table terminated yet -> idle everywhere
    walk(3, "R6");
    new_frame("R6");
    walk(2, "R6");

    // R2: directed runs 2/idle, 24/ch4, 1/idle, 5/ch3 on rx; different tx table (R4)
    wr(0, 0, 2, 0, 0, 0);
    wr(0, 1, 24, 4, 0, 0);
    wr(0, 2, 1, 0, 0, 0);
    wr(0, 3, 5, 3, 0, 1);
    wr(1, 0, 3, 1, 0, 0);
    wr(1, 1, 4, 5, 0, 1);
    new_frame("R2");
    walk(33, "R2");   // slots 32,33 past the table: R6
    idle(3, "R9");

    // R8: write mid-frame, current frame unaffected, next frame uses it
    new_frame("R8");
    walk(2, "R8");
    wr(1, 0, 2, 2, 0, 0);   // tx only (R4)
    walk(4, "R8");
    new_frame("R8");
    walk(10, "R4");

    // R7: rejected writes leave tables unchanged
    wr(0, 0, 0, 1, 0, 1);
    wr(0, 0, 65, 1, 0, 1);
    wr(1, 1, 3, 6, 0, 1);
    wr(1, 1, 3, 7, 0, 0);
    wr(0, 2, 3, 2, 4'h8, 1);
    new_frame("R7");
    walk(34, "R7");
    chk(wr_err == 1, "R7", "wr_err sticky", int'(wr_err), 1);

    // R5: frame start mid-run, and winning against a strobe
    walk(5, "R5");
    tick(1, 1);
    check_slot("R5");
    walk(4, "R5");

    // R3: 64 entries, final run of 64 slots
    for (int e = 0; e < 63; e++) wr(0, e, 1, e % 6, 0, 0);
    wr(0, 63, 64, 5, 0, 1);
    new_frame("R3");
    walk(130, "R3");

    // random frames (R2, R4, R5, R8, R9)
    for (int f = 0; f < 25; f++) begin
      for (int d = 0; d < 2; d++) begin
        len = 1 + int'($urandom % 8);
        for (int e = 0; e < len; e++)
          wr(d, e, 1 + int'($urandom % 8), int'($urandom % 6), 0, e == len - 1);
        if ($urandom % 3 == 0) wr(d, int'($urandom % 8), 0, int'($urandom % 8), 0, 1);
      end
      new_frame("R2");
      tot = 5 + int'($urandom % 60);
      for (int i = 0; i < tot; i++) begin
        if ($urandom % 4 == 0) idle(1 + int'($urandom % 2), "R9");
        if ($urandom % 20 == 0) wr(int'($urandom % 2), 0, 1 + int'($urandom % 8), int'($urandom % 6), 0, 0);
        next_slot("R2");
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule